// File: doc/BRIEF.md
# PCI-to-PCI Bridge Configuration Window Registers

This block holds the bridge-specific dwords of a Type 1 configuration header, dword indices 6 through 15 (byte offsets 0x18 to 0x3C). A configuration agent writes and reads them through a dword port that has a dword index, write data and per-byte enables. Read data is combinational from the stored state.

From the stored fields the block forms three forwarding windows: I/O, 32-bit memory and prefetchable memory. It publishes each window as a base and an exclusive end. Each window register keeps only the bits that its capability parameter allows. The low nibble of a capability parameter selects the addressing width, and that width decides whether the upper-address dwords can be written at all.

An I/O request is given as an address and a size in bytes. The block raises a forward indication when the command-register I/O enable is set and the whole access falls inside the I/O window.

Top module: `pci_bridge_cfg`

## Requirements
- R1: After reset every stored field is zero. Reads then return zero except for three things: the capability low nibbles in the window fields, and the interrupt pin parameter in bits 15:8 of dword 15. The windows then report base 0, an I/O end of 0x1000, and memory and prefetchable ends of 0x100000.
- R2: Dword 6 holds the primary bus number in bits 7:0, the secondary bus number in 15:8 and the subordinate bus number in 23:16. Bits 31:24 hold the secondary latency timer, which keeps only the bits set in LAT_MASK.
- R3: Dword 7 holds the I/O base in bits 7:0 and the I/O limit in 15:8. Bits 31:16 are the secondary status; they always read zero and ignore writes.
- R4: Dword 8 holds the memory base in bits 15:0 and the memory limit in 31:16. Dword 9 holds the prefetchable base and limit in the same layout. Each window field stores only the bits set in its capability parameter, masked with F0 or FFF0, and its low nibble always reads back the capability's low nibble.
- R5: Dwords 10 and 11 hold the upper 32 bits of the prefetchable base and limit. They are writable only when the low nibble of PREF_CAP is 1. Dword 12 holds the upper 16 bits of the I/O base in bits 15:0 and of the I/O limit in bits 31:16. It is writable only when the low nibble of IO_CAP is 1. Otherwise these dwords read zero.
- R6: The I/O window base is {upper16, io_base[7:4], 12'h000}. Its exclusive end is {upper16, io_limit[7:4], 12'h000} + 0x1000.
- R7: The memory window base is {mem_base[15:4], 20'h0}, and its end is {mem_limit[15:4], 20'h0} + 0x100000. The prefetchable window has the same form, with the upper 32 bits placed above it.
- R8: A write updates only the bytes whose enable bit is set. cfg_be[n] covers bits 8n+7:8n.
- R9: io_fwd is 1 exactly when io_en is 1, io_addr >= window base, and io_addr + io_size <= window end.
- R10: Dword 13 and every index outside 6 to 15 read zero. A write to any of them changes no register.
- R11: Dword 14 is the expansion ROM BAR and keeps only the bits set in ROM_MASK. Dword 15 holds the interrupt line in bits 7:0 (read-write), the interrupt pin in bits 15:8 (read-only, from a parameter) and the bridge control in bits 31:16 (read-write).
- R12: The window outputs change on the same clock edge that stores the write. They are therefore valid in the cycle that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw |
| io_en | input | 1 | Command-register I/O enable |
| io_addr | input | 32 | I/O request address |
| io_size | input | 3 | I/O request size in bytes |
| io_fwd | output | 1 | Request lies inside the enabled I/O window |
| io_win_base | output | 32 | I/O window base |
| io_win_end | output | 33 | I/O window exclusive end |
| mem_win_base | output | 32 | Memory window base |
| mem_win_end | output | 33 | Memory window exclusive end |
| pf_win_base | output | 64 | Prefetchable window base |
| pf_win_end | output | 65 | Prefetchable window exclusive end |

## Verification
The hardest case to reach is an access that ends exactly at the window's exclusive end. It needs both the base and the limit nibbles programmed and the upper I/O dword cleared, and the case sits beside one that overruns by a single byte. The stimulus programs a 4 KB window and probes its first byte, its last full dword, a dword that spills one byte past the end, and the same address with the enable clear. A second instance with narrow capabilities shows that the upper-address dwords refuse writes. A random phase then mixes partial byte enables over in-range and out-of-range indices.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam logic [5:0] DW_BUS   = 6'd6;
    localparam logic [5:0] DW_IOST  = 6'd7;
    localparam logic [5:0] DW_MEM   = 6'd8;
    localparam logic [5:0] DW_PF    = 6'd9;
    localparam logic [5:0] DW_PFBU  = 6'd10;
    localparam logic [5:0] DW_PFLU  = 6'd11;
    localparam logic [5:0] DW_IOUP  = 6'd12;
    localparam logic [5:0] DW_ROM   = 6'd14;
    localparam logic [5:0] DW_INTR  = 6'd15;

    typedef struct packed {
        logic [7:0]  pri_bus;
        logic [7:0]  sec_bus;
        logic [7:0]  sub_bus;
        logic [7:0]  sec_lat;
        logic [7:0]  io_base;
        logic [7:0]  io_lim;
        logic [15:0] mem_base;
        logic [15:0] mem_lim;
        logic [15:0] pf_base;
        logic [15:0] pf_lim;
        logic [31:0] pf_base_up;
        logic [31:0] pf_lim_up;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [31:0] rom_bar;
        logic [7:0]  int_line;
        logic [15:0] br_ctl;
    } bcfg_state_t;

    typedef struct packed {
        logic [31:0] io_base;
        logic [32:0] io_end;
        logic [31:0] mem_base;
        logic [32:0] mem_end;
        logic [63:0] pf_base;
        logic [64:0] pf_end;
    } bcfg_win_t;

endpackage

// File: rtl/bcfg_regs.sv
module bcfg_regs
    import bcfg_pkg::*;
#(
    parameter logic [7:0]  IO_CAP   = 8'hF1,
    parameter logic [15:0] MEM_CAP  = 16'hFFF0,
    parameter logic [15:0] PREF_CAP = 16'hFFF1,
    parameter logic [7:0]  LAT_MASK = 8'hF8,
    parameter logic [31:0] ROM_MASK = 32'hFFFF_F801,
    parameter logic [7:0]  INT_PIN  = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [3:0]  nx_io_base,
    output logic [3:0]  nx_io_lim,
    output logic [15:0] nx_io_base_up,
    output logic [15:0] nx_io_lim_up,
    output logic [11:0] nx_mem_base,
    output logic [11:0] nx_mem_lim,
    output logic [11:0] nx_pf_base,
    output logic [11:0] nx_pf_lim,
    output logic [31:0] nx_pf_base_up,
    output logic [31:0] nx_pf_lim_up
);

    localparam bit          IO32    = (IO_CAP[3:0] == 4'h1);
    localparam bit          PF64    = (PREF_CAP[3:0] == 4'h1);
    localparam logic [7:0]  IO_WM   = IO_CAP & 8'hF0;
    localparam logic [15:0] MEM_WM  = MEM_CAP & 16'hFFF0;
    localparam logic [15:0] PF_WM   = PREF_CAP & 16'hFFF0;
    localparam logic [7:0]  IO_NIB  = {4'h0, IO_CAP[3:0]};
    localparam logic [15:0] MEM_NIB = {12'h0, MEM_CAP[3:0]};
    localparam logic [15:0] PF_NIB  = {12'h0, PREF_CAP[3:0]};
    localparam int          NBYTES  = 4;

    bcfg_state_t st_d, st_q;
    logic [31:0] be_mask;
    logic [31:0] merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_bemask
        assign be_mask[8*b +: 8] = {8{cfg_be[b]}};
    end

    function automatic logic [31:0] view(bcfg_state_t s, logic [5:0] dw);
        logic [31:0] r;
        case (dw)
            DW_BUS:  r = {s.sec_lat, s.sub_bus, s.sec_bus, s.pri_bus};
            DW_IOST: r = {16'h0000, s.io_lim | IO_NIB, s.io_base | IO_NIB};
            DW_MEM:  r = {s.mem_lim | MEM_NIB, s.mem_base | MEM_NIB};
            DW_PF:   r = {s.pf_lim | PF_NIB, s.pf_base | PF_NIB};
            DW_PFBU: r = s.pf_base_up;
            DW_PFLU: r = s.pf_lim_up;
            DW_IOUP: r = {s.io_lim_up, s.io_base_up};
            DW_ROM:  r = s.rom_bar;
            DW_INTR: r = {s.br_ctl, INT_PIN, s.int_line};
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    always_comb begin
        cfg_rdata = view(st_q, cfg_dw);
        merged    = (cfg_rdata & ~be_mask) | (cfg_wdata & be_mask);
        st_d      = st_q;
        if (cfg_wr) begin
            case (cfg_dw)
                DW_BUS: begin
                    st_d.pri_bus = merged[7:0];
                    st_d.sec_bus = merged[15:8];
                    st_d.sub_bus = merged[23:16];
                    st_d.sec_lat = (st_q.sec_lat & ~LAT_MASK) | (merged[31:24] & LAT_MASK);
                end
                DW_IOST: begin
                    st_d.io_base = merged[7:0] & IO_WM;
                    st_d.io_lim  = merged[15:8] & IO_WM;
                end
                DW_MEM: begin
                    st_d.mem_base = merged[15:0] & MEM_WM;
                    st_d.mem_lim  = merged[31:16] & MEM_WM;
                end
                DW_PF: begin
                    st_d.pf_base = merged[15:0] & PF_WM;
                    st_d.pf_lim  = merged[31:16] & PF_WM;
                end
                DW_PFBU: if (PF64) st_d.pf_base_up = merged;
                DW_PFLU: if (PF64) st_d.pf_lim_up = merged;
                DW_IOUP: if (IO32) begin
                    st_d.io_base_up = merged[15:0];
                    st_d.io_lim_up  = merged[31:16];
                end
                DW_ROM:  st_d.rom_bar = merged & ROM_MASK;
                DW_INTR: begin
                    st_d.int_line = merged[7:0];
                    st_d.br_ctl   = merged[31:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nx_io_base    = st_d.io_base[7:4];
    assign nx_io_lim     = st_d.io_lim[7:4];
    assign nx_io_base_up = st_d.io_base_up;
    assign nx_io_lim_up  = st_d.io_lim_up;
    assign nx_mem_base   = st_d.mem_base[15:4];
    assign nx_mem_lim    = st_d.mem_lim[15:4];
    assign nx_pf_base    = st_d.pf_base[15:4];
    assign nx_pf_lim     = st_d.pf_lim[15:4];
    assign nx_pf_base_up = st_d.pf_base_up;
    assign nx_pf_lim_up  = st_d.pf_lim_up;

    // R2: an enabled secondary-bus byte lands in the register
    p_bus_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw == DW_BUS && cfg_be[1]) |=> (st_q.sec_bus == $past(cfg_wdata[15:8])));

    // R8: a disabled byte lane keeps its old value
    p_be_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw == DW_BUS && !cfg_be[0]) |=> $stable(st_q.pri_bus));

    // R10: without a write strobe nothing changes
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(st_q));

endmodule

// File: rtl/bcfg_window.sv
module bcfg_window
    import bcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  io_base,
    input  logic [3:0]  io_lim,
    input  logic [15:0] io_base_up,
    input  logic [15:0] io_lim_up,
    input  logic [11:0] mem_base,
    input  logic [11:0] mem_lim,
    input  logic [11:0] pf_base,
    input  logic [11:0] pf_lim,
    input  logic [31:0] pf_base_up,
    input  logic [31:0] pf_lim_up,
    output bcfg_win_t   win
);

    localparam int IO_GRAN_SH  = 12;
    localparam int MEM_GRAN_SH = 20;
    localparam logic [32:0] IO_STEP  = 33'd1 << IO_GRAN_SH;
    localparam logic [32:0] MEM_STEP = 33'd1 << MEM_GRAN_SH;
    localparam logic [64:0] PF_STEP  = 65'd1 << MEM_GRAN_SH;

    bcfg_win_t win_d, win_q;

    always_comb begin
        win_d.io_base  = {io_base_up, io_base, {IO_GRAN_SH{1'b0}}};
        win_d.io_end   = {1'b0, io_lim_up, io_lim, {IO_GRAN_SH{1'b0}}} + IO_STEP;
        win_d.mem_base = {mem_base, {MEM_GRAN_SH{1'b0}}};
        win_d.mem_end  = {1'b0, mem_lim, {MEM_GRAN_SH{1'b0}}} + MEM_STEP;
        win_d.pf_base  = {pf_base_up, pf_base, {MEM_GRAN_SH{1'b0}}};
        win_d.pf_end   = {1'b0, pf_lim_up, pf_lim, {MEM_GRAN_SH{1'b0}}} + PF_STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q         <= '0;
            win_q.io_end  <= IO_STEP;
            win_q.mem_end <= MEM_STEP;
            win_q.pf_end  <= PF_STEP;
        end else begin
            win_q <= win_d;
        end
    end

    assign win = win_q;

    // R6: I/O window edges sit on 4 KB boundaries
    p_io_gran_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.io_base[11:0] == 12'h0) && (win_q.io_end[11:0] == 12'h0));

    // R7: memory window edges sit on 1 MB boundaries
    p_mem_gran_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.mem_base[19:0] == 20'h0) && (win_q.mem_end[19:0] == 20'h0)
        && (win_q.pf_end[19:0] == 20'h0));

endmodule

// File: rtl/bcfg_io_decode.sv
module bcfg_io_decode (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_en,
    input  logic [31:0] io_addr,
    input  logic [2:0]  io_size,
    input  logic [31:0] win_base,
    input  logic [32:0] win_end,
    output logic        io_fwd
);

    logic [32:0] last_excl;

    always_comb begin
        last_excl = {1'b0, io_addr} + {30'd0, io_size};
        io_fwd    = io_en && (io_addr >= win_base) && (last_excl <= win_end);
    end

    // R9: forwarding needs the command-register enable
    p_fwd_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_fwd |-> io_en);

    // R9: a forwarded access never starts below the window
    p_fwd_above_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_fwd |-> (io_addr >= win_base));

endmodule

// File: rtl/pci_bridge_cfg.sv
module pci_bridge_cfg
    import bcfg_pkg::*;
#(
    parameter logic [7:0]  IO_CAP   = 8'hF1,
    parameter logic [15:0] MEM_CAP  = 16'hFFF0,
    parameter logic [15:0] PREF_CAP = 16'hFFF1,
    parameter logic [7:0]  LAT_MASK = 8'hF8,
    parameter logic [31:0] ROM_MASK = 32'hFFFF_F801,
    parameter logic [7:0]  INT_PIN  = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        io_en,
    input  logic [31:0] io_addr,
    input  logic [2:0]  io_size,
    output logic        io_fwd,
    output logic [31:0] io_win_base,
    output logic [32:0] io_win_end,
    output logic [31:0] mem_win_base,
    output logic [32:0] mem_win_end,
    output logic [63:0] pf_win_base,
    output logic [64:0] pf_win_end
);

    logic [3:0]  w_io_base, w_io_lim;
    logic [15:0] w_io_base_up, w_io_lim_up;
    logic [11:0] w_mem_base, w_mem_lim, w_pf_base, w_pf_lim;
    logic [31:0] w_pf_base_up, w_pf_lim_up;
    bcfg_win_t   win;

    bcfg_regs #(
        .IO_CAP(IO_CAP), .MEM_CAP(MEM_CAP), .PREF_CAP(PREF_CAP),
        .LAT_MASK(LAT_MASK), .ROM_MASK(ROM_MASK), .INT_PIN(INT_PIN)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .nx_io_base(w_io_base), .nx_io_lim(w_io_lim),
        .nx_io_base_up(w_io_base_up), .nx_io_lim_up(w_io_lim_up),
        .nx_mem_base(w_mem_base), .nx_mem_lim(w_mem_lim),
        .nx_pf_base(w_pf_base), .nx_pf_lim(w_pf_lim),
        .nx_pf_base_up(w_pf_base_up), .nx_pf_lim_up(w_pf_lim_up)
    );

    bcfg_window win_i (
        .clk(clk), .rst_n(rst_n),
        .io_base(w_io_base), .io_lim(w_io_lim),
        .io_base_up(w_io_base_up), .io_lim_up(w_io_lim_up),
        .mem_base(w_mem_base), .mem_lim(w_mem_lim),
        .pf_base(w_pf_base), .pf_lim(w_pf_lim),
        .pf_base_up(w_pf_base_up), .pf_lim_up(w_pf_lim_up),
        .win(win)
    );

    bcfg_io_decode dec_i (
        .clk(clk), .rst_n(rst_n),
        .io_en(io_en), .io_addr(io_addr), .io_size(io_size),
        .win_base(win.io_base), .win_end(win.io_end),
        .io_fwd(io_fwd)
    );

    assign io_win_base  = win.io_base;
    assign io_win_end   = win.io_end;
    assign mem_win_base = win.mem_base;
    assign mem_win_end  = win.mem_end;
    assign pf_win_base  = win.pf_base;
    assign pf_win_end   = win.pf_end;

endmodule

// File: tb/pci_bridge_cfg_tb_top.sv
`timescale 1ns/100ps
module pci_bridge_cfg_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [5:0] cfg_dw = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic io_en = 1'b0;
    logic [31:0] io_addr = '0;
    logic [2:0] io_size = 3'd1;

    logic [31:0] rd [2];
    logic        fwd [2];
    logic [31:0] iob [2];
    logic [32:0] ioe [2];
    logic [31:0] mb [2];
    logic [32:0] me [2];
    logic [63:0] pb [2];
    logic [64:0] pe [2];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // capabilities of the two instances: [0] wide, [1] narrow
    localparam logic [7:0]  C_IO  [2] = '{8'hF1, 8'hF0};
    localparam logic [15:0] C_MEM [2] = '{16'hFFF0, 16'hFFF0};
    localparam logic [15:0] C_PF  [2] = '{16'hFFF1, 16'hFFF0};
    localparam logic [7:0]  C_LAT [2] = '{8'hF8, 8'h00};
    localparam logic [31:0] C_ROM [2] = '{32'hFFFF_F801, 32'h0};
    localparam logic [7:0]  C_PIN [2] = '{8'h01, 8'h00};

    always #2 clk = ~clk;

    pci_bridge_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd[0]), .io_en(io_en), .io_addr(io_addr),
        .io_size(io_size), .io_fwd(fwd[0]), .io_win_base(iob[0]), .io_win_end(ioe[0]),
        .mem_win_base(mb[0]), .mem_win_end(me[0]), .pf_win_base(pb[0]), .pf_win_end(pe[0])
    );

    pci_bridge_cfg #(
        .IO_CAP(8'hF0), .MEM_CAP(16'hFFF0), .PREF_CAP(16'hFFF0),
        .LAT_MASK(8'h00), .ROM_MASK(32'h0), .INT_PIN(8'h00)
    ) dut_lo_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd[1]), .io_en(io_en), .io_addr(io_addr),
        .io_size(io_size), .io_fwd(fwd[1]), .io_win_base(iob[1]), .io_win_end(ioe[1]),
        .mem_win_base(mb[1]), .mem_win_end(me[1]), .pf_win_base(pb[1]), .pf_win_end(pe[1])
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] mdw [2][64];

    function automatic logic [31:0] wmask(int k, int i);
        case (i)
            6:  return {C_LAT[k], 24'hFF_FFFF};
            7:  return {16'h0, C_IO[k] & 8'hF0, C_IO[k] & 8'hF0};
            8:  return {C_MEM[k] & 16'hFFF0, C_MEM[k] & 16'hFFF0};
            9:  return {C_PF[k] & 16'hFFF0, C_PF[k] & 16'hFFF0};
            10, 11: return (C_PF[k][3:0] == 4'h1) ? 32'hFFFF_FFFF : 32'h0;
            12: return (C_IO[k][3:0] == 4'h1) ? 32'hFFFF_FFFF : 32'h0;
            14: return C_ROM[k];
            15: return 32'hFFFF_00FF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] cmask(int k, int i);
        case (i)
            7:  return {16'h0, 4'h0, C_IO[k][3:0], 4'h0, C_IO[k][3:0]};
            8:  return {12'h0, C_MEM[k][3:0], 12'h0, C_MEM[k][3:0]};
            9:  return {12'h0, C_PF[k][3:0], 12'h0, C_PF[k][3:0]};
            15: return {16'h0, C_PIN[k], 8'h0};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++)
                for (int i = 0; i < 64; i++) mdw[k][i] = 32'h0;
        end else if (cfg_wr) begin
            logic [31:0] bm;
            for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{cfg_be[b]}};
            for (int k = 0; k < 2; k++) begin
                logic [31:0] m;
                m = wmask(k, int'(cfg_dw)) & bm;
                mdw[k][cfg_dw] = (mdw[k][cfg_dw] & ~m) | (cfg_wdata & m);
            end
        end
    end

    function automatic logic [31:0] exp_rd(int k, int i);
        return mdw[k][i] | cmask(k, i);
    endfunction
    function automatic logic [64:0] e_iob(int k);
        return {33'h0, mdw[k][12][15:0], mdw[k][7][7:4], 12'h0};
    endfunction
    function automatic logic [64:0] e_ioe(int k);
        return {33'h0, mdw[k][12][31:16], mdw[k][7][15:12], 12'h0} + 65'h1000;
    endfunction
    function automatic logic [64:0] e_mb(int k);
        return {33'h0, mdw[k][8][15:4], 20'h0};
    endfunction
    function automatic logic [64:0] e_me(int k);
        return {33'h0, mdw[k][8][31:20], 20'h0} + 65'h10_0000;
    endfunction
    function automatic logic [64:0] e_pb(int k);
        return {1'b0, mdw[k][10], mdw[k][9][15:4], 20'h0};
    endfunction
    function automatic logic [64:0] e_pe(int k);
        return {1'b0, mdw[k][11], mdw[k][9][31:20], 20'h0} + 65'h10_0000;
    endfunction
    function automatic bit e_fwd(int k);
        logic [64:0] a;
        a = {33'h0, io_addr};
        return io_en && (a >= e_iob(k)) && (a + 65'(io_size) <= e_ioe(k));
    endfunction

    function automatic string req_of(int i);
        case (i)
            6: return "R2";
            7: return "R3";
            8, 9: return "R4";
            10, 11, 12: return "R5";
            14, 15: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison of both instances against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            for (int k = 0; k < 2; k++) begin
                chk(rd[k] == exp_rd(k, int'(cfg_dw)), req_of(int'(cfg_dw)), 65'(rd[k]), 65'(exp_rd(k, int'(cfg_dw))));
                chk(65'(iob[k]) == e_iob(k) && 65'(ioe[k]) == e_ioe(k), "R6", {32'h0, ioe[k]}, e_ioe(k));
                chk(65'(mb[k]) == e_mb(k) && 65'(me[k]) == e_me(k), "R7", {32'h0, me[k]}, e_me(k));
                chk(65'(pb[k]) == e_pb(k) && pe[k] == e_pe(k), "R7", pe[k], e_pe(k));
                chk(fwd[k] == e_fwd(k), "R9", 65'(fwd[k]), 65'(e_fwd(k)));
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wr(logic [5:0] dw, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rdchk(int k, logic [5:0] dw, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_dw = dw;
        #0.5;
        chk(rd[k] == exp, tag, 65'(rd[k]), 65'(exp));
    endtask

    task automatic fwdchk(bit en, logic [31:0] a, logic [2:0] sz, bit exp);
        @(negedge clk);
        io_en = en; io_addr = a; io_size = sz;
        #0.5;
        chk(fwd[0] == exp, "R9", 65'(fwd[0]), 65'(exp));
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdchk(0, 6'd7, 32'h0000_0101, "R1");
        rdchk(0, 6'd8, 32'h0000_0000, "R1");
        rdchk(0, 6'd9, 32'h0001_0001, "R1");
        rdchk(0, 6'd15, 32'h0000_0100, "R1");
        chk(ioe[0] == 33'h1000 && iob[0] == 32'h0, "R1", 65'(ioe[0]), 65'h1000);
        chk(me[0] == 33'h10_0000 && pe[0] == 65'h10_0000, "R1", 65'(me[0]), 65'h10_0000);
        // R2 bus numbers and masked latency timer
        wr(6'd6, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd6, 32'hF8FF_FFFF, "R2");
        rdchk(1, 6'd6, 32'h00FF_FFFF, "R2");
        // R3 secondary status ignored, R4 capability nibbles
        wr(6'd7, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd7, 32'h0000_F1F1, "R3");
        rdchk(1, 6'd7, 32'h0000_F0F0, "R4");
        wr(6'd8, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd8, 32'hFFF0_FFF0, "R4");
        // R5 conditional upper registers
        wr(6'd12, 32'h1234_5678, 4'hF);
        rdchk(0, 6'd12, 32'h1234_5678, "R5");
        rdchk(1, 6'd12, 32'h0000_0000, "R5");
        wr(6'd10, 32'hDEAD_BEEF, 4'hF);
        rdchk(0, 6'd10, 32'hDEAD_BEEF, "R5");
        rdchk(1, 6'd10, 32'h0000_0000, "R5");
        // R6 I/O window 0x2000..0x3000
        wr(6'd12, 32'h0, 4'hF);
        wr(6'd7, 32'h0000_2020, 4'hF);
        #0.5;
        chk(iob[0] == 32'h2000 && ioe[0] == 33'h3000, "R6", 65'(ioe[0]), 65'h3000);
        // R9 forwarding boundaries
        fwdchk(1'b1, 32'h1FFF, 3'd1, 1'b0);
        fwdchk(1'b1, 32'h2000, 3'd4, 1'b1);
        fwdchk(1'b1, 32'h2FFC, 3'd4, 1'b1);
        fwdchk(1'b1, 32'h2FFD, 3'd4, 1'b0);
        fwdchk(1'b1, 32'h3000, 3'd1, 1'b0);
        fwdchk(1'b0, 32'h2800, 3'd2, 1'b0);
        // R7 and R12: windows valid in the cycle after each write
        wr(6'd8, 32'h0020_0010, 4'hF);
        #0.5;
        chk(mb[0] == 32'h0010_0000 && me[0] == 33'h0030_0000, "R12", 65'(me[0]), 65'h0030_0000);
        wr(6'd10, 32'h1, 4'hF);
        wr(6'd11, 32'h2, 4'hF);
        wr(6'd9, 32'h0050_0040, 4'hF);
        #0.5;
        chk(pb[0] == 64'h1_0040_0000 && pe[0] == 65'h2_0060_0000, "R7", pe[0], 65'h2_0060_0000);
        // R8 partial byte enables
        wr(6'd6, 32'hAABB_CCDD, 4'b0101);
        rdchk(0, 6'd6, 32'hF8BB_FFDD, "R8");
        // R10 unimplemented indices
        wr(6'd13, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd13, 32'h0, "R10");
        wr(6'd16, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd16, 32'h0, "R10");
        wr(6'd2, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd2, 32'h0, "R10");
        rdchk(0, 6'd6, 32'hF8BB_FFDD, "R10");
        // R11 ROM BAR and interrupt dword
        wr(6'd14, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd14, 32'hFFFF_F801, "R11");
        rdchk(1, 6'd14, 32'h0, "R11");
        wr(6'd15, 32'hFFFF_FFFF, 4'hF);
        rdchk(0, 6'd15, 32'hFFFF_01FF, "R11");
        rdchk(1, 6'd15, 32'hFFFF_00FF, "R11");
        // random phase, compared every clock by the monitor
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            cfg_wr    = 1'($urandom_range(0, 1));
            cfg_dw    = 6'($urandom_range(0, 17));
            cfg_be    = 4'($urandom);
            cfg_wdata = $urandom;
            io_en     = ($urandom_range(0, 3) != 0);
            io_addr   = ($urandom_range(0, 1) == 1) ? $urandom
                                                    : {14'h0, 2'($urandom_range(0, 3)), 16'($urandom)};
            io_size   = 3'(1 << $urandom_range(0, 2));
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        #1.5;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule